// File: doc/BRIEF.md
# Dual 8-bit / Single 16-bit Buffered PWM Counter

This block produces pulse-width modulated outputs from two 8-bit channel counters. Each counter advances on a tick input that comes from an external clock-select stage. Each channel can run left-aligned, where it counts up and wraps, or center-aligned, where it counts up to the period and then back down. Period and duty are double-buffered. Software writes the buffer registers at any time. The active copies pick up the new values only at the end of a period, or at once when software writes the counter.

A concatenate bit joins the two channels into one 16-bit channel. The 16-bit channel takes its enable, polarity and alignment from channel 0, drives its waveform on output 0, and forces output 1 low. The counter can be read while it runs, and reading it does not disturb the count. In 16-bit mode, reading the low counter byte captures the high byte into a holding register. A later read of the high byte returns that held value, so a low-then-high read sequence is always coherent.

Access is through a small byte-wide register port. A write takes effect at the clock edge where `wr_en` is high. A read returns its data one cycle after `rd_en`, with `rd_valid` high for that one cycle. The port has no back-pressure: every access completes in a fixed number of cycles, and no request is ever stalled.

Top module: `dual_pwm_counter`

Register addresses (`addr`):

| Address | Register |
|---|---|
| 0 | control |
| 1 | counter, low byte (channel 0) |
| 2 | counter, high byte (channel 1) |
| 3 | period buffer, low (channel 0) |
| 4 | period buffer, high (channel 1) |
| 5 | duty buffer, low (channel 0) |
| 6 | duty buffer, high (channel 1) |

Control bits:

| Bit | Function |
|---|---|
| 0 | enable, channel 0 |
| 1 | enable, channel 1 |
| 2 | polarity, channel 0 |
| 3 | polarity, channel 1 |
| 4 | center-aligned, channel 0 |
| 5 | center-aligned, channel 1 |
| 6 | concatenate |

## Requirements
- R1: After reset, all registers and counters are 0, `rd_valid` is 0, and `pwm_out` is 2'b11, which is the inactive level when polarity is 0.
- R2: In left-aligned mode (control bit 4 = 0 for channel 0), each tick with the channel enabled advances the counter from 0 up to period-1, and the next tick returns it to 0.
- R3: In center-aligned mode (control bit 4 = 1), the counter counts up from 0 to the period value, then counts down to 0, and repeats. It never exceeds the active period.
- R4: A write of any value to a counter address forces the count to 0 and the direction to up, and loads the active period and duty from their buffers at the same edge. In 16-bit mode, a write to either counter byte resets the whole 16-bit counter.
- R5: Other than through a counter write, the active period and duty take the buffer values only at the end of a period. In left-aligned mode that is the wrap to 0. In center-aligned mode it is the step down to 0.
- R6: While a channel's enable bit is 0, its counter holds its value through ticks. When the enable bit returns to 1, counting resumes from the held value.
- R7: With polarity 1, the left-aligned output is high while count < duty and low otherwise. Polarity 0 inverts the output.
- R8: In center-aligned mode, the output is at the active level while count < duty, counting both up and down, so it changes level at the duty match in each direction.
- R9: An active period of 0 keeps the counter at 0 and the output at its inactive level. An active duty that is greater than or equal to a nonzero period gives a constant active output.
- R10: With control bit 6 = 1, the channels form one 16-bit counter with period {period high, period low} and duty {duty high, duty low}. It is controlled by channel 0's bits and drives `pwm_out[0]`, while `pwm_out[1]` is 0.
- R11: In 16-bit mode, a read of address 1 returns the low count byte and latches the high byte. A read of address 2 returns the latched byte.
- R12: A read returns its data exactly one cycle after `rd_en`, with `rd_valid` high for that cycle only. Reads never change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the selected clock source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| pwm_out | output | 2 | Channel outputs |

## Verification
The hardest case to reach is a read in 16-bit mode where the high byte changes between the low-byte read and the high-byte read. The stimulus reads the low byte at a count of 250, then issues ten more ticks so the count carries into the high byte, and only then reads the high byte. The expected result is the stale latched value rather than the live one. A second hard case is a buffered period change that must wait for the wrap: the period buffer is rewritten in the middle of a cycle, and the counter is then run past the old wrap point. At that point the expected count differs between a deferred load and an immediate one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PER_HI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DUTY_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_DUTY_HI = 3'd6;

  localparam int B_EN     = 0;  // bits 0,1
  localparam int B_POL    = 2;  // bits 2,3
  localparam int B_CENTER = 4;  // bits 4,5
  localparam int B_CAT    = 6;
endpackage

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         pol,
  input  logic         center,
  input  logic         cnt_clr,
  input  logic [W-1:0] per_buf,
  input  logic [W-1:0] duty_buf,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_o,
  output logic         out_o
);
  logic [W-1:0] cnt, per_act, duty_act;
  logic         down;
  logic         active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      down     <= 1'b0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (cnt_clr) begin
      cnt      <= '0;
      down     <= 1'b0;
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end else if (tick && en) begin
      if (per_act == '0) begin
        cnt  <= '0;
        down <= 1'b0;
      end else if (!center) begin
        down <= 1'b0;
        if (cnt >= per_act - 1'b1) begin
          cnt      <= '0;
          per_act  <= per_buf;
          duty_act <= duty_buf;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!down) begin
        if (cnt >= per_act) begin
          cnt <= cnt - 1'b1;
          if (cnt == {{(W-1){1'b0}}, 1'b1}) begin
            per_act  <= per_buf;
            duty_act <= duty_buf;
          end else begin
            down <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt <= {{(W-1){1'b0}}, 1'b1}) begin
          cnt      <= '0;
          down     <= 1'b0;
          per_act  <= per_buf;
          duty_act <= duty_buf;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    active = (per_act != '0) && ((duty_act >= per_act) || (cnt < duty_act));
    out_o  = active ? pol : ~pol;
  end

  assign cnt_o = cnt;
  assign per_o = per_act;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [BYTE_W-1:0]      ctrl,
  output logic [1:0][BYTE_W-1:0] per_buf,
  output logic [1:0][BYTE_W-1:0] duty_buf,
  output logic [1:0]             clr8,
  output logic                   clr16
);
  logic cat, hit_lo, hit_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      per_buf  <= '0;
      duty_buf <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:    ctrl        <= wr_data;
        A_PER_LO:  per_buf[0]  <= wr_data;
        A_PER_HI:  per_buf[1]  <= wr_data;
        A_DUTY_LO: duty_buf[0] <= wr_data;
        A_DUTY_HI: duty_buf[1] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    cat    = ctrl[B_CAT];
    hit_lo = wr_en && (addr == A_CNT_LO);
    hit_hi = wr_en && (addr == A_CNT_HI);
    clr8   = {hit_hi && !cat, hit_lo && !cat};
    clr16  = (hit_lo || hit_hi) && cat;
  end
endmodule

// File: rtl/dual_pwm_counter.sv
module dual_pwm_counter
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [1:0]        pwm_out
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0]      ctrl;
  logic [1:0][BYTE_W-1:0] per_buf, duty_buf;
  logic [1:0]             clr8;
  logic                   clr16;
  logic                   cat;
  logic [1:0][BYTE_W-1:0] cnt8, per8;
  logic [1:0]             out8;
  logic [WIDE_W-1:0]      cnt16, per16;
  logic                   out16;
  logic [BYTE_W-1:0]      hi_hold;

  assign cat = ctrl[B_CAT];

  pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl(ctrl), .per_buf(per_buf), .duty_buf(duty_buf),
    .clr8(clr8), .clr16(clr16)
  );

  for (genvar k = 0; k < 2; k++) begin : g_ch
    pwm_core #(.W(BYTE_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .en(ctrl[B_EN+k]), .pol(ctrl[B_POL+k]), .center(ctrl[B_CENTER+k]),
      .cnt_clr(clr8[k]), .per_buf(per_buf[k]), .duty_buf(duty_buf[k]),
      .cnt_o(cnt8[k]), .per_o(per8[k]), .out_o(out8[k])
    );
  end

  pwm_core #(.W(WIDE_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .en(ctrl[B_EN] && cat), .pol(ctrl[B_POL]), .center(ctrl[B_CENTER]),
    .cnt_clr(clr16), .per_buf({per_buf[1], per_buf[0]}),
    .duty_buf({duty_buf[1], duty_buf[0]}),
    .cnt_o(cnt16), .per_o(per16), .out_o(out16)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      hi_hold  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (addr)
          A_CTRL:    rd_data <= ctrl;
          A_CNT_LO:  rd_data <= cat ? cnt16[BYTE_W-1:0] : cnt8[0];
          A_CNT_HI:  rd_data <= cat ? hi_hold : cnt8[1];
          A_PER_LO:  rd_data <= per_buf[0];
          A_PER_HI:  rd_data <= per_buf[1];
          A_DUTY_LO: rd_data <= duty_buf[0];
          A_DUTY_HI: rd_data <= duty_buf[1];
          default:   rd_data <= '0;
        endcase
        if (cat && addr == A_CNT_LO) hi_hold <= cnt16[WIDE_W-1:BYTE_W];
      end
    end
  end

  assign pwm_out = cat ? {1'b0, out16} : out8;
endmodule

// File: rtl/dual_pwm_counter_chk.sv
module dual_pwm_counter_chk
  import pwm_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      addr,
  input logic                   rd_en,
  input logic                   rd_valid,
  input logic [BYTE_W-1:0]      ctrl,
  input logic [1:0][BYTE_W-1:0] cnt8,
  input logic [1:0][BYTE_W-1:0] per8,
  input logic [2*BYTE_W-1:0]    cnt16,
  input logic [2*BYTE_W-1:0]    per16,
  input logic [1:0]             pwm_out
);
  assert_cnt_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNT_LO && !ctrl[B_CAT]) |=> (cnt8[0] == '0));

  assert_wide_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_CNT_HI) && ctrl[B_CAT]) |=> (cnt16 == '0));

  assert_hold_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_EN] && !(wr_en && (addr == A_CNT_LO || addr == A_CTRL))) |=> $stable(cnt8[0]));

  assert_hold_ch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_EN+1] && !(wr_en && (addr == A_CNT_HI || addr == A_CTRL))) |=> $stable(cnt8[1]));

  assert_center_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_CENTER] |-> (cnt8[0] <= per8[0]));

  assert_zero_period_ch0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_CAT] && per8[0] == '0) |-> (pwm_out[0] == !ctrl[B_POL]));

  assert_zero_period_ch1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[B_CAT] && per8[1] == '0) |-> (pwm_out[1] == !ctrl[B_POL+1]));

  assert_zero_period_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_CAT] && per16 == '0) |-> (pwm_out[0] == !ctrl[B_POL]));

  assert_upper_low_in_cat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_CAT] |-> !pwm_out[1]);

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind dual_pwm_counter dual_pwm_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rd_en(rd_en),
  .rd_valid(rd_valid), .ctrl(ctrl), .cnt8(cnt8), .per8(per8),
  .cnt16(cnt16), .per16(per16), .pwm_out(pwm_out)
);

// File: tb/tb_dual_pwm_counter.sv
module tb_dual_pwm_counter;
  import pwm_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       rd_valid;
  logic [1:0] pwm_out;

  int checks = 0, errors = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  dual_pwm_counter dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data from the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) check("R12 unexpected rd_valid", 16'd1, 16'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, {8'd0, rd_data}, {8'd0, it.exp});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog expired", 16'd1, 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm_out after reset", {14'd0, pwm_out}, 16'h3);
    check("R1 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
    rd(A_CNT_LO, 8'h00, "R1 counter after reset");
    rd(A_PER_LO, 8'h00, "R1 period after reset");

    // left-aligned, period 5, duty 2, polarity 1
    wr(A_PER_LO, 8'd5);
    wr(A_DUTY_LO, 8'd2);
    wr(A_CTRL, 8'h05);
    wr(A_CNT_LO, 8'hFF);
    check("R7 active at count 0 pol1", {15'd0, pwm_out[0]}, 16'd1);
    check("R9 idle channel 1 inactive", {15'd0, pwm_out[1]}, 16'd1);
    ticks(3);
    rd(A_CNT_LO, 8'd3, "R2 count after 3 ticks");
    rd(A_CNT_LO, 8'd3, "R12 repeated read unchanged");
    check("R7 low once count reaches duty", {15'd0, pwm_out[0]}, 16'd0);
    ticks(2);
    rd(A_CNT_LO, 8'd0, "R2 wrap to 0 at period");
    check("R7 high again after wrap", {15'd0, pwm_out[0]}, 16'd1);

    // polarity 0 inverts
    wr(A_CTRL, 8'h01);
    check("R7 polarity 0 inverts", {15'd0, pwm_out[0]}, 16'd0);

    // disable holds
    ticks(2);
    wr(A_CTRL, 8'h04);
    ticks(4);
    rd(A_CNT_LO, 8'd2, "R6 count held while disabled");
    wr(A_CTRL, 8'h05);
    ticks(1);
    rd(A_CNT_LO, 8'd3, "R6 count resumes from held value");

    // buffered period waits for the wrap
    wr(A_PER_LO, 8'd8);
    ticks(1);
    ticks(1);
    rd(A_CNT_LO, 8'd0, "R5 old period still active at wrap");
    ticks(6);
    rd(A_CNT_LO, 8'd6, "R5 new period loaded at wrap");
    rd(A_PER_LO, 8'd8, "R5 period buffer readback");

    // counter write effects and duty >= period
    wr(A_CNT_LO, 8'h5A);
    rd(A_CNT_LO, 8'd0, "R4 counter write clears count");
    wr(A_DUTY_LO, 8'd9);
    wr(A_CNT_LO, 8'h00);
    for (int i = 0; i < 8; i++) begin
      ticks(1);
      check("R9 duty above period constant active", {15'd0, pwm_out[0]}, 16'd1);
    end

    // period 0
    wr(A_PER_LO, 8'd0);
    wr(A_CNT_LO, 8'h00);
    ticks(3);
    rd(A_CNT_LO, 8'd0, "R9 period 0 keeps count at 0");
    check("R9 period 0 output inactive", {15'd0, pwm_out[0]}, 16'd0);

    // center-aligned, period 4, duty 2
    wr(A_PER_LO, 8'd4);
    wr(A_DUTY_LO, 8'd2);
    wr(A_CTRL, 8'h15);
    wr(A_CNT_LO, 8'h00);
    ticks(6);
    rd(A_CNT_LO, 8'd2, "R3 count on the way down");
    check("R8 inactive at duty match going down", {15'd0, pwm_out[0]}, 16'd0);
    ticks(1);
    check("R8 active below duty going down", {15'd0, pwm_out[0]}, 16'd1);
    ticks(2);
    rd(A_CNT_LO, 8'd1, "R3 count up again after 0");
    ticks(4);
    rd(A_CNT_LO, 8'd3, "R3 count down from peak");
    wr(A_CNT_LO, 8'h11);
    ticks(1);
    rd(A_CNT_LO, 8'd1, "R4 direction set to up by counter write");

    // concatenated 16-bit, period 300, duty 2
    wr(A_CTRL, 8'h45);
    wr(A_PER_HI, 8'h01);
    wr(A_PER_LO, 8'h2C);
    wr(A_CNT_LO, 8'h00);
    ticks(250);
    check("R10 upper output forced low", {15'd0, pwm_out[1]}, 16'd0);
    check("R10 wide output inactive past duty", {15'd0, pwm_out[0]}, 16'd0);
    rd(A_CNT_LO, 8'hFA, "R11 low byte at count 250");
    ticks(10);
    rd(A_CNT_HI, 8'h00, "R11 high byte is the latched one");
    rd(A_CNT_LO, 8'h04, "R10 low byte at count 260");
    rd(A_CNT_HI, 8'h01, "R11 high byte at count 260");
    ticks(50);
    rd(A_CNT_LO, 8'h0A, "R10 wide wrap at period 300");
    rd(A_CNT_HI, 8'h00, "R10 wide high byte after wrap");
    ticks(250);
    wr(A_CNT_HI, 8'h77);
    rd(A_CNT_LO, 8'h00, "R10 high byte write resets low byte");
    rd(A_CNT_HI, 8'h00, "R10 high byte write resets high byte");

    repeat (2) @(negedge clk);
    check("R12 all reads returned", sb.size(), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule